// File: doc/BRIEF.md
# Burst-Mode Synchronous Serial Port

This block is a full-duplex synchronous serial port for a processor that needs to talk to serial converters and codecs. Words written by the processor go into a four-entry transmit queue. Each queued word is sent in a burst frame of its own: a frame-sync pulse, then sixteen bits shifted out most significant bit first. A separate receive path watches a frame-sync input. After each sync it gathers sixteen bits into a four-entry receive queue. The processor reads the received words from the same data address it writes to.

The serial bit clock comes from outside. It is brought into the system clock domain by a two-stage synchronizer, and the port then acts on the rising and falling edges it detects. The frame-sync and receive-data inputs pass through synchronizers of the same depth, so they stay aligned with the clock edges. The serial clock must therefore be well below half the system clock rate.

The processor side has two addresses. Address 0 is the data address: a write pushes the transmit queue and a read pops the receive queue. Address 1 is the control/status register. It holds the two enables and a self-clearing flush bit. It also holds four sticky flags, cleared by writing 1 to them, and the fill levels of both queues. The transmit and receive interrupt outputs follow their flags.

Top module: `burst_serial_port`

## Requirements
- R1: After reset, fsx, dx and dx_oe are low, both interrupts are low, and the control/status register reads 0.
- R2: A write to address 0 appends the word to the transmit queue, which holds 4 words. A write while the queue is full is discarded and sets the transmit-overflow flag (status bit 6). Status bits [10:8] give the transmit level.
- R3: When transmission is enabled (control bit 0), the shifter is idle and the transmit queue is not empty, the next serial-clock rising edge raises fsx. fsx stays high for exactly one serial-clock period.
- R4: On the serial-clock falling edge that follows, the oldest queued word moves into the transmit shifter. At the same time the transmit flag (status bit 4) and tx_irq go high.
- R5: The 16 bits are driven on dx MSB first, one bit per rising edge, starting at the rising edge that ends fsx. dx_oe is high only while bits are driven, and it falls at the rising edge after the last bit.
- R6: Every word gets its own frame, and words leave in the order they were written. When the transmit queue is empty, no further fsx pulse occurs.
- R7: When reception is enabled (control bit 1), a falling edge that sees fsr high arms the receiver. Each of the next 16 falling edges with fsr low samples dr, MSB first. The 16th sample pushes the word into the receive queue and sets the receive flag (status bit 5) and rx_irq.
- R8: A read of address 0 returns the oldest received word and removes it from the queue. A read with the queue empty returns 0. Status bits [14:12] give the receive level.
- R9: A word that completes while the receive queue holds 4 words is discarded and sets the receive-overflow flag (status bit 7). The queued words are kept.
- R10: Writing 1 to any of status bits 4 to 7 clears that flag. Writing 0 to them leaves the flags unchanged.
- R11: With control bit 0 clear, no frame starts and queued words stay queued. With control bit 1 clear, nothing is received.
- R12: Writing control bit 2 as 1 empties both queues, aborts any frame in progress (fsx and dx_oe low), disarms the receiver and clears all four flags. The enables are taken from the same write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | External serial bit clock |
| fsr | input | 1 | Receive frame-sync input |
| dr | input | 1 | Serial receive data |
| bus_wr | input | 1 | Processor write strobe |
| bus_rd | input | 1 | Processor read strobe |
| bus_addr | input | 1 | 0 = data, 1 = control/status |
| bus_wdata | input | 16 | Processor write data |
| bus_rdata | output | 16 | Processor read data |
| fsx | output | 1 | Transmit frame-sync pulse |
| dx | output | 1 | Serial transmit data |
| dx_oe | output | 1 | Drive enable for dx (low = high impedance) |
| tx_irq | output | 1 | Transmit interrupt (transmit flag) |
| rx_irq | output | 1 | Receive interrupt (receive flag) |

## Verification
Receive overflow is the hardest case to reach. The receive queue has to be full, and then a complete, correctly framed word has to arrive before anything is read. The bench gets there by looping fsx and dx back onto fsr and dr. It queues four words, clocks them out until the receive queue fills, then sends a fifth frame. A soft flush in the middle of a frame is also provoked, after the bench has counted enough serial clocks for the shifter to be driving dx.

// File: rtl/burst_serial_port.sv
module burst_serial_port #(
  parameter int DW    = 16,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sclk,
  input  logic          fsr,
  input  logic          dr,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic          bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          fsx,
  output logic          dx,
  output logic          dx_oe,
  output logic          tx_irq,
  output logic          rx_irq
);
  localparam int AW = $clog2(DEPTH);
  localparam int LW = AW + 1;
  localparam int CW = $clog2(DW);
  localparam logic [LW-1:0] FULL = LW'(DEPTH);
  localparam logic [CW-1:0] LAST = CW'(DW - 1);

  typedef enum logic [1:0] {TX_IDLE, TX_SYNC, TX_LOAD, TX_SHIFT} tx_st_e;

  // edge detection on the synchronized serial clock
  logic [2:0] sclk_s;
  logic [1:0] fsr_s, dr_s;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sclk_s <= '0; fsr_s <= '0; dr_s <= '0;
    end else begin
      sclk_s <= {sclk_s[1:0], sclk};
      fsr_s  <= {fsr_s[0], fsr};
      dr_s   <= {dr_s[0], dr};
    end

  logic sclk_rise, sclk_fall, fsr_q, dr_q;
  assign sclk_rise = sclk_s[1] & ~sclk_s[2];
  assign sclk_fall = ~sclk_s[1] & sclk_s[2];
  assign fsr_q = fsr_s[1];
  assign dr_q  = dr_s[1];

  // processor strobes
  logic wr_data, wr_ctrl, rd_data, soft_rst;
  assign wr_data  = bus_wr & ~bus_addr;
  assign wr_ctrl  = bus_wr & bus_addr;
  assign rd_data  = bus_rd & ~bus_addr;
  assign soft_rst = wr_ctrl & bus_wdata[2];

  logic tx_en, rx_en;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tx_en <= 1'b0; rx_en <= 1'b0;
    end else if (wr_ctrl) begin
      tx_en <= bus_wdata[0]; rx_en <= bus_wdata[1];
    end

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // transmit queue
  logic [DW-1:0] tx_mem [DEPTH];
  logic [AW-1:0] tx_wp, tx_rp;
  logic [LW-1:0] tx_lvl;
  logic          tx_push, tx_pop;
  tx_st_e        tx_st;

  assign tx_push = wr_data & (tx_lvl != FULL) & ~soft_rst;
  assign tx_pop  = (tx_st == TX_SYNC) & sclk_fall & ~soft_rst;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; tx_lvl <= '0;
    end else if (soft_rst) begin
      tx_wp <= '0; tx_rp <= '0; tx_lvl <= '0;
    end else begin
      if (tx_push) tx_wp <= nxt(tx_wp);
      if (tx_pop)  tx_rp <= nxt(tx_rp);
      tx_lvl <= tx_lvl + LW'(tx_push) - LW'(tx_pop);
    end

  always_ff @(posedge clk)
    if (tx_push) tx_mem[tx_wp] <= bus_wdata;

  // transmit framing and shifter
  logic [DW-1:0] xsr;
  logic [CW-1:0] tbit;
  logic          fsx_q, oe_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tx_st <= TX_IDLE; fsx_q <= 1'b0; oe_q <= 1'b0; xsr <= '0; tbit <= '0;
    end else if (soft_rst) begin
      tx_st <= TX_IDLE; fsx_q <= 1'b0; oe_q <= 1'b0;
    end else begin
      case (tx_st)
        TX_IDLE:
          if (sclk_rise && tx_en && tx_lvl != '0) begin
            fsx_q <= 1'b1; tx_st <= TX_SYNC;
          end
        TX_SYNC:
          if (sclk_fall) begin
            xsr <= tx_mem[tx_rp]; tx_st <= TX_LOAD;
          end
        TX_LOAD:
          if (sclk_rise) begin
            fsx_q <= 1'b0; oe_q <= 1'b1; tbit <= '0; tx_st <= TX_SHIFT;
          end
        TX_SHIFT:
          if (sclk_rise) begin
            if (tbit == LAST) begin
              oe_q <= 1'b0; tx_st <= TX_IDLE;
            end else begin
              xsr  <= {xsr[DW-2:0], 1'b0};
              tbit <= tbit + 1'b1;
            end
          end
        default: tx_st <= TX_IDLE;
      endcase
    end

  assign fsx   = fsx_q;
  assign dx_oe = oe_q;
  assign dx    = oe_q & xsr[DW-1];

  // receive shifter
  logic [DW-1:0] rsr;
  logic [CW-1:0] rbit;
  logic          rx_arm, rx_done;
  logic [DW-1:0] rx_word;

  assign rx_done = sclk_fall & rx_en & ~fsr_q & rx_arm & (rbit == LAST) & ~soft_rst;
  assign rx_word = {rsr[DW-2:0], dr_q};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rsr <= '0; rbit <= '0; rx_arm <= 1'b0;
    end else if (soft_rst || !rx_en) begin
      rx_arm <= 1'b0; rbit <= '0;
    end else if (sclk_fall) begin
      if (fsr_q) begin
        rx_arm <= 1'b1; rbit <= '0;
      end else if (rx_arm) begin
        rsr <= rx_word;
        if (rbit == LAST) rx_arm <= 1'b0;
        else              rbit   <= rbit + 1'b1;
      end
    end

  // receive queue
  logic [DW-1:0] rx_mem [DEPTH];
  logic [AW-1:0] rx_wp, rx_rp;
  logic [LW-1:0] rx_lvl;
  logic          rx_push, rx_pop;

  assign rx_push = rx_done & (rx_lvl != FULL);
  assign rx_pop  = rd_data & (rx_lvl != '0) & ~soft_rst;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_wp <= '0; rx_rp <= '0; rx_lvl <= '0;
    end else if (soft_rst) begin
      rx_wp <= '0; rx_rp <= '0; rx_lvl <= '0;
    end else begin
      if (rx_push) rx_wp <= nxt(rx_wp);
      if (rx_pop)  rx_rp <= nxt(rx_rp);
      rx_lvl <= rx_lvl + LW'(rx_push) - LW'(rx_pop);
    end

  always_ff @(posedge clk)
    if (rx_push) rx_mem[rx_wp] <= rx_word;

  // sticky flags, set wins over write-one-to-clear
  logic tx_flag, rx_flag, tx_ovf, rx_ovf;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tx_flag <= 1'b0; rx_flag <= 1'b0; tx_ovf <= 1'b0; rx_ovf <= 1'b0;
    end else if (soft_rst) begin
      tx_flag <= 1'b0; rx_flag <= 1'b0; tx_ovf <= 1'b0; rx_ovf <= 1'b0;
    end else begin
      tx_flag <= tx_pop                          | (tx_flag & ~(wr_ctrl & bus_wdata[4]));
      rx_flag <= rx_done                         | (rx_flag & ~(wr_ctrl & bus_wdata[5]));
      tx_ovf  <= (wr_data & (tx_lvl == FULL))    | (tx_ovf  & ~(wr_ctrl & bus_wdata[6]));
      rx_ovf  <= (rx_done & (rx_lvl == FULL))    | (rx_ovf  & ~(wr_ctrl & bus_wdata[7]));
    end

  assign tx_irq = tx_flag;
  assign rx_irq = rx_flag;

  logic [DW-1:0] status;
  always_comb begin
    status = '0;
    status[0] = tx_en;
    status[1] = rx_en;
    status[4] = tx_flag;
    status[5] = rx_flag;
    status[6] = tx_ovf;
    status[7] = rx_ovf;
    status[8 +: LW]  = tx_lvl;
    status[12 +: LW] = rx_lvl;
  end

  assign bus_rdata = bus_addr ? status : ((rx_lvl != '0) ? rx_mem[rx_rp] : '0);

  AST_TX_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    tx_lvl <= FULL); // R2
  AST_FSX_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    fsx |-> !dx_oe); // R3
  AST_TXFLAG_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_irq) |-> $past(sclk_fall)); // R4
  AST_OE_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dx_oe) |-> $past(sclk_rise)); // R5
  AST_DX_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (dx_oe && $past(dx_oe) && !$past(sclk_rise)) |-> $stable(dx)); // R5
  AST_RXFLAG_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_irq) |-> $past(sclk_fall)); // R7
  AST_RX_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    rx_lvl <= FULL); // R9
endmodule

// File: tb/burst_serial_port_tb.sv
module burst_serial_port_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0, bus_addr = 1'b0;
  logic [15:0] bus_wdata = '0, bus_rdata;
  logic fsx, dx, dx_oe, tx_irq, rx_irq;
  logic loop = 1'b1, fsr_drv = 1'b0, dr_drv = 1'b0;
  logic fsr, dr;
  int n_vec = 0, n_bad = 0, fsx_seen = 0;
  bit done = 0;

  always #10 clk = ~clk;

  assign fsr = loop ? fsx : fsr_drv;
  assign dr  = loop ? (dx & dx_oe) : dr_drv;

  burst_serial_port u_dut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .fsr(fsr), .dr(dr),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .fsx(fsx), .dx(dx), .dx_oe(dx_oe), .tx_irq(tx_irq), .rx_irq(rx_irq));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bwrite(input logic a, input logic [15:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic bread(input logic a, output logic [15:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1; #1 d = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic rise();
    @(negedge clk); sclk = 1'b1;
    repeat (6) @(negedge clk);
    if (fsx) fsx_seen++;
  endtask

  task automatic fall();
    @(negedge clk); sclk = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin rise(); fall(); end
  endtask

  task automatic t_reset();
    logic [15:0] s;
    chk("R1 fsx", fsx, 0); chk("R1 dx_oe", dx_oe, 0); chk("R1 dx", dx, 0);
    chk("R1 tx_irq", tx_irq, 0); chk("R1 rx_irq", rx_irq, 0);
    bread(1'b1, s); chk("R1 status", s, 16'h0000);
  endtask

  task automatic t_single();
    logic [15:0] w = 16'hA5C3, s, d;
    bwrite(1'b1, 16'h0003);
    bwrite(1'b0, w);
    rise(); chk("R3 fsx high", fsx, 1); chk("R3 oe low", dx_oe, 0);
    fall(); chk("R4 tx_irq", tx_irq, 1);
    for (int i = 15; i >= 0; i--) begin
      rise();
      chk("R5 oe", dx_oe, 1); chk("R5 dx bit", dx, w[i]);
      if (i == 15) chk("R3 fsx one period", fsx, 0);
      fall();
    end
    chk("R7 rx_irq", rx_irq, 1);
    rise(); chk("R5 oe release", dx_oe, 0); fall();
    bread(1'b1, s); chk("R7 status", s, 16'h1033);
    bread(1'b0, d); chk("R8 data", d, w);
    bread(1'b1, s); chk("R8 level after pop", s, 16'h0033);
    bread(1'b0, d); chk("R8 empty read", d, 16'h0000);
    bwrite(1'b1, 16'h0003); bread(1'b1, s); chk("R10 write zero", s, 16'h0033);
    bwrite(1'b1, 16'h0013); bread(1'b1, s); chk("R10 clear tx", s, 16'h0023);
    chk("R10 tx_irq low", tx_irq, 0);
    bwrite(1'b1, 16'h0023); bread(1'b1, s); chk("R10 clear rx", s, 16'h0003);
  endtask

  task automatic t_order();
    logic [15:0] s, d;
    for (int k = 0; k < 5; k++) bwrite(1'b0, 16'h1357 + 16'(k) * 16'h2222);
    bread(1'b1, s); chk("R2 full and overflow", s, 16'h0443);
    fsx_seen = 0;
    run(4 * 18 + 6);
    chk("R6 frame count", fsx_seen, 4);
    bread(1'b1, s); chk("R6 levels", s, 16'h4073);
    for (int k = 0; k < 4; k++) begin
      bread(1'b0, d); chk("R6 order", d, 16'h1357 + 16'(k) * 16'h2222);
    end
    bwrite(1'b1, 16'h00F3); bread(1'b1, s); chk("R10 clear all", s, 16'h0003);
  endtask

  task automatic t_rx_ovf();
    logic [15:0] s, d;
    for (int k = 0; k < 4; k++) bwrite(1'b0, 16'h0F0F ^ (16'(k) << 12));
    run(4 * 18 + 2);
    bwrite(1'b0, 16'hBEEF);
    run(20);
    bread(1'b1, s); chk("R9 overflow", s, 16'h40B3);
    for (int k = 0; k < 4; k++) begin
      bread(1'b0, d); chk("R9 kept words", d, 16'h0F0F ^ (16'(k) << 12));
    end
    bwrite(1'b1, 16'h00F3);
  endtask

  task automatic t_rx_manual();
    logic [15:0] v = 16'h6D2B, s, d;
    loop = 1'b0; fsr_drv = 1'b1; dr_drv = 1'b1;
    run(1);
    fsr_drv = 1'b0;
    for (int i = 15; i >= 0; i--) begin dr_drv = v[i]; run(1); end
    chk("R7 rx_irq manual", rx_irq, 1);
    bread(1'b0, d); chk("R7 manual word", d, v);
    bread(1'b1, s); chk("R7 manual status", s, 16'h0023);
    bwrite(1'b1, 16'h0023);
    loop = 1'b1;
  endtask

  task automatic t_enables();
    logic [15:0] s;
    bwrite(1'b1, 16'h0001);
    bwrite(1'b0, 16'h4242);
    fsx_seen = 0; run(20);
    chk("R11 tx only frame", fsx_seen, 1);
    bread(1'b1, s); chk("R11 rx disabled", s, 16'h0011);
    bwrite(1'b1, 16'h0012);
    bwrite(1'b0, 16'h9999);
    fsx_seen = 0; run(20);
    chk("R11 tx disabled", fsx_seen, 0);
    bread(1'b1, s); chk("R11 word kept", s, 16'h0102);
    bwrite(1'b1, 16'h0046);
    bread(1'b1, s); chk("R12 flush", s, 16'h0002);
    bwrite(1'b1, 16'h0003);
    bwrite(1'b0, 16'hFFFF);
    run(6);
    chk("R5 mid frame oe", dx_oe, 1);
    bwrite(1'b1, 16'h0007);
    @(negedge clk);
    chk("R12 abort oe", dx_oe, 0); chk("R12 abort fsx", fsx, 0);
    bread(1'b1, s); chk("R12 abort status", s, 16'h0003);
    run(20);
    bread(1'b1, s); chk("R12 quiet after abort", s, 16'h0003);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_single();
    t_order();
    t_rx_ovf();
    t_rx_manual();
    t_enables();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule